// File: doc/BRIEF.md
# Shared Mailbox Interrupt Aggregator

This block gathers the FULL and EMPTY level conditions of up to eight shared mailboxes into one 16-bit status word. It then routes that word through a separate enable mask for each of several shared interrupt outputs. Each output is the OR of the status bits its mask selects, taken through one register stage. Nothing is latched. An interrupt stays up for as long as an enabled condition holds, and it drops as soon as the condition goes away or software clears the enable.

Software reaches the block through a plain register port with a write strobe, a read strobe, a 12-bit address and 32-bit data. Read data is registered. It offers:
- one enable register per interrupt line;
- the raw status word;
- a vector word that shows which lines are asserted;
- a read-only capability word that reports how many mailboxes, semaphores, doorbells and interrupt lines the instance was built with.

The usual pattern is for a producer to enable its EMPTY bit only while a message is outstanding, and for a consumer to keep its FULL bit enabled.

Top module: `mbxIrqAggregator`

## Requirements
- R1: After reset every line's enable mask reads zero and every interrupt output is low.
- R2: The status word at address 0x304 holds the EMPTY condition of mailbox i in bit i and its FULL condition in bit 8+i, for i from 0 to 7, sampled at the clock edge of the read. Bits 31:16 read as zero.
- R3: The enable mask of line x is at address 0x100 + 4*x. It stores write bits 15:0, and bits 31:16 read as zero.
- R4: Interrupt output x goes high in the cycle after any bit of (status AND enable mask x) is set, judged with the values just before the clock edge. It stays high as long as that condition holds, and it goes low in the cycle after the condition clears.
- R5: The capability word at address 0x380 reads as follows: mailbox count in bits 3:0, shared semaphore count in 7:4, arbitrated semaphore count in 11:8, doorbell count in 15:12, interrupt line count in 20:16, and zero in the other bits. With the default parameters (8, 2, 1, 3, 4) it reads 0x00043128.
- R6: The vector word at address 0x300 reads bit x as the current level of interrupt output x, with the other bits zero.
- R7: Writes to the status, vector and capability addresses, to enable slots beyond the last line, and to any other address have no effect on any register.
- R8: Read data appears on the cycle after the read strobe. A read of an unmapped or misaligned address returns zero.
- R9: A write to the enable mask of one line leaves the masks of all other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mbxFull | input | NUM_MBOX | FULL level of each mailbox |
| mbxEmpty | input | NUM_MBOX | EMPTY level of each mailbox |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after regRdEn |
| irqOut | output | NUM_LINES | Shared interrupt outputs |

## Verification
A software write to a line's enable mask can land in the same cycle as a change in the mailbox levels. The bench provokes this by driving the enable write and a new EMPTY level at the same clock edge. It expects the output to stay low for one cycle, because the old mask is still in force at that edge, and then to rise a cycle later. A status read is likewise issued in the same cycle as an input change, and the bench expects the value sampled at that edge.

// File: rtl/mbxIrqPkg.sv
package mbxIrqPkg;
  localparam int ADDR_W    = 12;
  localparam int MAX_LINES = 16;

  localparam logic [ADDR_W-1:0] ADDR_EN_BASE = 12'h100;
  localparam logic [ADDR_W-1:0] ADDR_VECTOR  = 12'h300;
  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 12'h304;
  localparam logic [ADDR_W-1:0] ADDR_CAPS    = 12'h380;

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic [MAX_LINES-1:0] lineWr;
    logic [MAX_LINES-1:0] lineRd;
    logic                 rdStatus;
    logic                 rdVector;
    logic                 rdCap;
    logic                 rdAny;
  } regStrobe_t;
endpackage

// File: rtl/mbxIrqCtrl.sv
module mbxIrqCtrl
  import mbxIrqPkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] EN_END = ADDR_W'(int'(ADDR_EN_BASE) + 4 * NUM_LINES);

  logic              enHit;
  logic [ADDR_W-1:0] lineIdx;

  assign enHit   = (regAddr >= ADDR_EN_BASE) && (regAddr < EN_END) && (regAddr[1:0] == 2'b00);
  assign lineIdx = (regAddr - ADDR_EN_BASE) >> 2;

  for (genvar g = 0; g < MAX_LINES; g++) begin : gLineDec
    if (g < NUM_LINES) begin : gLive
      assign strb.lineWr[g] = regWrEn && enHit && (lineIdx == ADDR_W'(g));
      assign strb.lineRd[g] = regRdEn && enHit && (lineIdx == ADDR_W'(g));
    end else begin : gDead
      assign strb.lineWr[g] = 1'b0;
      assign strb.lineRd[g] = 1'b0;
    end
  end

  assign strb.rdStatus = regRdEn && (regAddr == ADDR_STATUS);
  assign strb.rdVector = regRdEn && (regAddr == ADDR_VECTOR);
  assign strb.rdCap    = regRdEn && (regAddr == ADDR_CAPS);
  assign strb.rdAny    = regRdEn;

  // R8: at most one read source is selected at a time
  p_one_read_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.lineRd, strb.rdStatus, strb.rdVector, strb.rdCap}));

  // R9: at most one enable register is written at a time
  p_one_write_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.lineWr));

  // R7: no register write strobe without a write request
  p_no_stray_wr_r7: assert property (@(posedge clk) disable iff (rst)
    !regWrEn |-> (strb.lineWr == '0));
endmodule

// File: rtl/mbxIrqDatapath.sv
module mbxIrqDatapath
  import mbxIrqPkg::*;
#(
  parameter int          NUM_MBOX  = 8,
  parameter int          NUM_LINES = 4,
  parameter logic [31:0] CAP_WORD  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_MBOX-1:0]  mbxFull,
  input  logic [NUM_MBOX-1:0]  mbxEmpty,
  input  logic [31:0]          regWrData,
  input  regStrobe_t           strb,
  output logic [NUM_LINES-1:0] irqOut,
  output logic [31:0]          regRdData
);
  localparam int HALF_W = 8;
  localparam int STAT_W = 2 * HALF_W;

  logic [STAT_W-1:0] statusWord;
  logic [STAT_W-1:0] enMask [NUM_LINES];
  logic [31:0]       rdNext;

  always_comb begin
    statusWord = '0;
    for (int i = 0; i < NUM_MBOX; i++) begin
      statusWord[i]          = mbxEmpty[i];
      statusWord[HALF_W + i] = mbxFull[i];
    end
  end

  for (genvar x = 0; x < NUM_LINES; x++) begin : gLine
    always_ff @(posedge clk) begin
      if (rst) begin
        enMask[x] <= '0;
        irqOut[x] <= 1'b0;
      end else begin
        if (strb.lineWr[x]) enMask[x] <= regWrData[STAT_W-1:0];
        irqOut[x] <= |(statusWord & enMask[x]);
      end
    end

    // R4: an enabled condition raises the line on the next cycle
    p_irq_rise_r4: assert property (@(posedge clk) disable iff (rst)
      (|(statusWord & enMask[x])) |=> irqOut[x]);

    // R4: with no enabled condition the line is low on the next cycle
    p_irq_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      !(|(statusWord & enMask[x])) |=> !irqOut[x]);

    // R1: masks and outputs start cleared after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (enMask[x] == '0 && !irqOut[x]));
  end

  always_comb begin
    rdNext = '0;
    for (int x = 0; x < NUM_LINES; x++)
      if (strb.lineRd[x]) rdNext = rdNext | 32'(enMask[x]);
    if (strb.rdStatus) rdNext = rdNext | 32'(statusWord);
    if (strb.rdVector) rdNext = rdNext | 32'(irqOut);
    if (strb.rdCap)    rdNext = rdNext | CAP_WORD;
  end

  always_ff @(posedge clk) begin
    if (rst)            regRdData <= '0;
    else if (strb.rdAny) regRdData <= rdNext;
  end

  // R2: status reads carry nothing above bit 15
  p_status_upper_r2: assert property (@(posedge clk) disable iff (rst)
    $past(strb.rdStatus) |-> (regRdData[31:STAT_W] == '0));

  // R5: capability reads return the build-time word
  p_cap_word_r5: assert property (@(posedge clk) disable iff (rst)
    $past(strb.rdCap) |-> (regRdData == CAP_WORD));
endmodule

// File: rtl/mbxIrqAggregator.sv
module mbxIrqAggregator
  import mbxIrqPkg::*;
#(
  parameter int NUM_MBOX  = 8,
  parameter int NUM_SSEM  = 2,
  parameter int NUM_ASEM  = 1,
  parameter int NUM_DBELL = 3,
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_MBOX-1:0]  mbxFull,
  input  logic [NUM_MBOX-1:0]  mbxEmpty,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [11:0]          regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic [NUM_LINES-1:0] irqOut
);
  localparam logic [31:0] CAP_WORD = {11'b0, 5'(NUM_LINES), 4'(NUM_DBELL),
                                      4'(NUM_ASEM), 4'(NUM_SSEM), 4'(NUM_MBOX)};

  regStrobe_t strb;

  mbxIrqCtrl #(.NUM_LINES(NUM_LINES)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  mbxIrqDatapath #(
    .NUM_MBOX  (NUM_MBOX),
    .NUM_LINES (NUM_LINES),
    .CAP_WORD  (CAP_WORD)
  ) uData (
    .clk       (clk),
    .rst       (rst),
    .mbxFull   (mbxFull),
    .mbxEmpty  (mbxEmpty),
    .regWrData (regWrData),
    .strb      (strb),
    .irqOut    (irqOut),
    .regRdData (regRdData)
  );
endmodule

// File: tb/sim_mbxIrqAggregator.sv
module sim_mbxIrqAggregator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mbxFull = '0, mbxEmpty = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  irqOut;

  int checks = 0, failures = 0;
  logic [15:0] enModel [4];

  always #2 clk = ~clk;

  mbxIrqAggregator u0 (
    .clk(clk), .rst(rst), .mbxFull(mbxFull), .mbxEmpty(mbxEmpty),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    @(negedge clk); regRdEn = 1'b0; d = regRdData;
  endtask

  task automatic setEn(input int x, input logic [15:0] m);
    wrReg(12'(12'h100 + 4 * x), {16'hA5A5, m});
    enModel[x] = m;
  endtask

  function automatic logic [3:0] expIrq();
    logic [3:0] r;
    for (int x = 0; x < 4; x++) r[x] = |({mbxFull, mbxEmpty} & enModel[x]);
    return r;
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int x = 0; x < 4; x++) enModel[x] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: cleared masks and quiet outputs out of reset
    chk("R1 irq", 32'(irqOut), 0);
    for (int x = 0; x < 4; x++) begin
      rdReg(12'(12'h100 + 4 * x), d); chk("R1 mask", d, 0);
    end
    // R5: capability word
    rdReg(12'h380, d); chk("R5 caps", d, 32'h0004_3128);

    // R2: status sweep
    for (int i = 0; i < 256; i++) begin
      logic [15:0] p;
      p = 16'(i * 40503) ^ 16'(i << 7);
      {mbxFull, mbxEmpty} = p;
      rdReg(12'h304, d); chk("R2 status", d, {16'h0, p});
    end

    // R3 / R9: per-line masks, upper half dropped, others untouched
    {mbxFull, mbxEmpty} = '0;
    for (int x = 0; x < 4; x++) setEn(x, 16'(16'h1111 * (x + 1)));
    for (int x = 0; x < 4; x++) begin
      rdReg(12'(12'h100 + 4 * x), d); chk("R3 R9 mask", d, {16'h0, enModel[x]});
    end
    setEn(2, 16'hFFFF);
    for (int x = 0; x < 4; x++) begin
      rdReg(12'(12'h100 + 4 * x), d); chk("R9 neighbours", d, {16'h0, enModel[x]});
    end

    // R7: writes to read-only or unmapped addresses change nothing
    wrReg(12'h304, 32'hFFFF_FFFF);
    wrReg(12'h300, 32'hFFFF_FFFF);
    wrReg(12'h380, 32'h0);
    wrReg(12'h110, 32'hFFFF_FFFF);
    wrReg(12'h102, 32'hFFFF_FFFF);
    wrReg(12'h0FC, 32'hFFFF_FFFF);
    for (int x = 0; x < 4; x++) begin
      rdReg(12'(12'h100 + 4 * x), d); chk("R7 mask kept", d, {16'h0, enModel[x]});
    end
    rdReg(12'h380, d); chk("R7 caps kept", d, 32'h0004_3128);
    rdReg(12'h304, d); chk("R7 status raw", d, 0);

    // R8: unmapped and misaligned reads
    rdReg(12'h110, d); chk("R8 beyond lines", d, 0);
    rdReg(12'h101, d); chk("R8 misaligned", d, 0);
    rdReg(12'h200, d); chk("R8 unmapped", d, 0);

    // R4: single-bit sweep on every line
    for (int x = 0; x < 4; x++) setEn(x, 16'h0);
    for (int x = 0; x < 4; x++) begin
      for (int b = 0; b < 16; b++) begin
        setEn(x, 16'(1 << b));
        {mbxFull, mbxEmpty} = 16'(1 << b);
        @(negedge clk); chk("R4 bit hit", 32'(irqOut), 32'(1 << x));
        {mbxFull, mbxEmpty} = ~16'(1 << b);
        @(negedge clk); chk("R4 bit miss", 32'(irqOut), 0);
        setEn(x, 16'h0);
      end
    end

    // R4 / R6: mixed masks over many patterns
    setEn(0, 16'h00FF); setEn(1, 16'hFF00); setEn(2, 16'h0F0F); setEn(3, 16'h8001);
    for (int i = 0; i < 300; i++) begin
      {mbxFull, mbxEmpty} = 16'(i * 16'h9E37) & 16'(i * 16'h0421);
      @(negedge clk); chk("R4 pattern", 32'(irqOut), 32'(expIrq()));
      if (i % 10 == 0) begin
        rdReg(12'h300, d); chk("R6 vector", d, 32'(expIrq()));
      end
    end

    // R4: level held for many cycles, then released
    {mbxFull, mbxEmpty} = 16'h0001;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); chk("R4 level hold", 32'(irqOut), 32'b1101);
    end
    {mbxFull, mbxEmpty} = 16'h0000;
    @(negedge clk); chk("R4 release", 32'(irqOut), 0);

    // R4: enable write in the same cycle as a status change
    setEn(1, 16'h0000);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 12'h104; regWrData = 32'h0000_0004;
    mbxEmpty[2] = 1'b1;
    @(negedge clk); regWrEn = 1'b0; enModel[1] = 16'h0004;
    chk("R4 same-cycle old mask", 32'(irqOut[1]), 0);
    @(negedge clk); chk("R4 same-cycle new mask", 32'(irqOut[1]), 1);
    // R2: status read in the same cycle as an input change
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 12'h304; mbxFull[7] = 1'b1;
    @(negedge clk); regRdEn = 1'b0;
    chk("R2 same-cycle status", regRdData, 32'h0000_8004);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule